// File: doc/BRIEF.md
# ACPI Sleep State Sequencer

This block moves a system between the working state S0 and the sleep states S1, S3, S4 and S5. Software loads a 3-bit sleep-type code and pulses the sleep-enable bit. The sequencer first asserts the processor stop-clock output and waits for the processor's acknowledge, or for a programmable timeout. It then drives the power-cut outputs for the chosen state. The power-cut outputs are cumulative: S3 cuts non-critical power, S4 also cuts memory power, and S5 adds the final cut.

A power button held low for a long, continuous interval forces an immediate entry to S5. This path skips the stop-clock handshake and is timed only by the slow real-time-clock enable tick. A wake event in any sleep state sets a sticky wake-status flag. The block then releases the power cuts in reverse order, one tick apart, and releases stop-clock last before it returns to S0.

The states are ON (S0), STOPREQ (stop-clock handshake), S1, S3, S4 and S5, plus three release states. DROP5 still holds the S3 and S4 cuts, DROP4 holds only the S3 cut, and DROP3 holds only stop-clock. The transitions are:
- accept: ON to STOPREQ.
- settle: STOPREQ to the target state, on acknowledge or timeout.
- wake: from S5 to DROP5, from S4 to DROP4, and from S3 or S1 to DROP3.
- step: DROP5 to DROP4, DROP4 to DROP3, and DROP3 to ON, each on a tick.
- override: from any state to S5.

Top module: `acpi_sleep_seq`

## Requirements
- R1: A cycle with `cmd_wr`=1, `cmd_en`=1 and a valid `cmd_type` in ON asserts `cpu_stop_clk` from the next cycle, with all power cuts still off. The valid codes are 1 = S1, 5 = S3, 6 = S4 and 7 = S5.
- R2: A write with `cmd_en`=0 has no effect on any output. A write with `cmd_en`=1 and code 0, 2, 3 or 4 also has no effect on any output.
- R3: In STOPREQ, the power-cut outputs stay off until `stop_ack` is sampled high. The target state's outputs then appear in the next cycle.
- R4: With no acknowledge, STOPREQ lasts `ack_timeout`+1 cycles and then enters the target state.
- R5: S1 asserts `cpu_stop_clk` and no power cuts. `cpu_sleep` is asserted only if `cmd_psleep` was 1 in the accepting write.
- R6: S3 asserts `pwr_cut_s3`. S4 asserts `pwr_cut_s3` and `pwr_cut_s4`. S5 asserts all three cuts. `cpu_stop_clk` stays high in every sleep state.
- R7: `pwr_btn_n` sampled low on HOLD_TICKS consecutive `rtc_tick` cycles puts the outputs in the S5 pattern in the next cycle, from any state, with no handshake. Releasing the button restarts the count.
- R8: A wake event in a sleep state drops `cpu_sleep` at once and drops the highest active cut in the next cycle. Each remaining cut is released on each following `rtc_tick`, highest first. `cpu_stop_clk` is released on the tick after the last cut is gone.
- R9: `wake_sts` is set in the cycle after a wake event is accepted in a sleep state, and it stays set until `sts_clr` is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R10: Sleep commands issued outside ON are ignored. Wake events outside a sleep state are ignored. The sleep-enable bit acts as a single-cycle strobe.
- R11: During reset, all outputs are 0 and the block is in ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle enable at the real-time-clock rate |
| cmd_wr | input | 1 | Control register write strobe |
| cmd_type | input | 3 | Sleep-type code |
| cmd_en | input | 1 | Sleep-enable bit of the write |
| cmd_psleep | input | 1 | Use the processor-sleep output in S1 |
| sts_clr | input | 1 | Write-1-to-clear for the wake status |
| ack_timeout | input | TMO_W | Handshake timeout in cycles |
| stop_ack | input | 1 | Processor stop-grant acknowledge |
| wake_evt | input | 1 | Enabled wake event |
| pwr_btn_n | input | 1 | Power button, active low |
| cpu_stop_clk | output | 1 | Processor stop-clock request |
| cpu_sleep | output | 1 | Processor sleep request |
| pwr_cut_s3 | output | 1 | Cut non-critical power |
| pwr_cut_s4 | output | 1 | Cut memory power |
| pwr_cut_s5 | output | 1 | Final power cut |
| wake_sts | output | 1 | Sticky wake status |

## Verification
The assertions assume that every input is synchronous to `clk` and that `ack_timeout` does not change while a handshake is running. The timer bound holds only when the limit is stable. The stimulus changes inputs only on the falling edge. It reloads `ack_timeout` only while the block is in ON, and it drives `stop_ack`, `wake_evt` and `sts_clr` as single-cycle pulses. The override test holds the button across a known number of ticks. The test then releases the button, so that one hold yields exactly one override.

// File: rtl/acpi_sleep_pkg.sv
package acpi_sleep_pkg;

    typedef enum logic [3:0] {
        ST_ON,
        ST_STOPREQ,
        ST_S1,
        ST_S3,
        ST_S4,
        ST_S5,
        ST_DROP5,
        ST_DROP4,
        ST_DROP3
    } slp_state_t;

    localparam logic [2:0] CODE_S1 = 3'd1;
    localparam logic [2:0] CODE_S3 = 3'd5;
    localparam logic [2:0] CODE_S4 = 3'd6;
    localparam logic [2:0] CODE_S5 = 3'd7;

    function automatic logic code_ok(input logic [2:0] code);
        return (code == CODE_S1) || (code == CODE_S3) ||
               (code == CODE_S4) || (code == CODE_S5);
    endfunction

    function automatic slp_state_t code_target(input logic [2:0] code);
        slp_state_t t;
        unique case (code)
            CODE_S1: t = ST_S1;
            CODE_S3: t = ST_S3;
            CODE_S4: t = ST_S4;
            default: t = ST_S5;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/btn_hold_counter.sv
module btn_hold_counter #(
    parameter int HOLD_TICKS = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    output logic fire
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] SAT  = CW'(HOLD_TICKS);

    logic [CW-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (btn_n) begin
            held_q <= '0;
        end else if (tick && held_q != SAT) begin
            held_q <= held_q + 1'b1;
        end
    end

    assign fire = !btn_n && tick && (held_q == LAST);

    // the count saturates and a released button restarts it (R7)
    assert_hold_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= SAT);
    assert_release_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        btn_n |=> held_q == '0);
endmodule

// File: rtl/ack_timer.sv
module ack_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (!run) begin
            wait_q <= '0;
        end else if (wait_q != limit) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    assign expired = run && (wait_q == limit);

    // with a stable limit the wait never passes it (R4)
    assert_tmr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(limit)) |-> wait_q <= limit);
endmodule

// File: rtl/wake_status.sv
module wake_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic sts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sts <= 1'b0;
        else if (set) sts <= 1'b1;
        else if (clr) sts <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> sts);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && clr) |=> !sts);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> sts == $past(sts));
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
    import acpi_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_wr,
    input  logic [2:0] cmd_type,
    input  logic       cmd_en,
    input  logic       cmd_psleep,
    input  logic       stop_ack,
    input  logic       tmr_expired,
    input  logic       wake_evt,
    input  logic       ovr_fire,
    output logic       tmr_run,
    output logic       wake_taken,
    output logic       stop_clk,
    output logic       cpu_sleep,
    output logic       cut_s3,
    output logic       cut_s4,
    output logic       cut_s5
);
    slp_state_t state_q, state_d;
    slp_state_t tgt_q, tgt_d;
    logic       psl_q, psl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ON;
            tgt_q   <= ST_S1;
            psl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            psl_q   <= psl_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        tgt_d      = tgt_q;
        psl_d      = psl_q;
        wake_taken = 1'b0;
        if (ovr_fire) begin
            state_d = ST_S5;
        end else begin
            unique case (state_q)
                ST_ON: begin
                    if (cmd_wr && cmd_en && code_ok(cmd_type)) begin
                        state_d = ST_STOPREQ;
                        tgt_d   = code_target(cmd_type);
                        psl_d   = cmd_psleep;
                    end
                end
                ST_STOPREQ: begin
                    if (stop_ack || tmr_expired) state_d = tgt_q;
                end
                ST_S1, ST_S3: begin
                    if (wake_evt) begin
                        state_d    = ST_DROP3;
                        wake_taken = 1'b1;
                    end
                end
                ST_S4: begin
                    if (wake_evt) begin
                        state_d    = ST_DROP4;
                        wake_taken = 1'b1;
                    end
                end
                ST_S5: begin
                    if (wake_evt) begin
                        state_d    = ST_DROP5;
                        wake_taken = 1'b1;
                    end
                end
                ST_DROP5: if (tick) state_d = ST_DROP4;
                ST_DROP4: if (tick) state_d = ST_DROP3;
                ST_DROP3: if (tick) state_d = ST_ON;
                default:  state_d = ST_ON;
            endcase
        end
    end

    always_comb begin
        tmr_run   = (state_q == ST_STOPREQ);
        stop_clk  = (state_q != ST_ON);
        cpu_sleep = (state_q == ST_S1) && psl_q;
        cut_s3    = (state_q == ST_S3) || (state_q == ST_S4) || (state_q == ST_S5) ||
                    (state_q == ST_DROP5) || (state_q == ST_DROP4);
        cut_s4    = (state_q == ST_S4) || (state_q == ST_S5) || (state_q == ST_DROP5);
        cut_s5    = (state_q == ST_S5);
    end

    // a command is accepted only from ON, and it first asks for stop-clock (R1, R10)
    assert_accept_from_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPREQ && $past(state_q) != ST_STOPREQ) |-> $past(state_q) == ST_ON);
    assert_no_accept_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ON && !ovr_fire && state_q != ST_STOPREQ) |=> state_q != ST_STOPREQ);
    // a power cut rises only after a handshake or an override (R3, R7)
    assert_entry_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cut_s3) |-> ($past(state_q) == ST_STOPREQ || $past(ovr_fire)));
    assert_override_s5_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_fire |=> cut_s5);
    assert_s1_no_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_S1) |-> (!cut_s3 && stop_clk));
    assert_cut_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_s5 |-> cut_s4) and (cut_s4 |-> cut_s3) and (cut_s3 |-> stop_clk));
    // stop-clock falls only from the last release step (R8)
    assert_clk_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_clk) |-> ($past(state_q) == ST_DROP3 && $past(tick)));
    assert_one_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cut_s4) && !$past(ovr_fire)) |-> (cut_s3 && !cut_s5));
endmodule

// File: rtl/acpi_sleep_seq.sv
module acpi_sleep_seq #(
    parameter int HOLD_TICKS = 131072,
    parameter int TMO_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             cmd_wr,
    input  logic [2:0]       cmd_type,
    input  logic             cmd_en,
    input  logic             cmd_psleep,
    input  logic             sts_clr,
    input  logic [TMO_W-1:0] ack_timeout,
    input  logic             stop_ack,
    input  logic             wake_evt,
    input  logic             pwr_btn_n,
    output logic             cpu_stop_clk,
    output logic             cpu_sleep,
    output logic             pwr_cut_s3,
    output logic             pwr_cut_s4,
    output logic             pwr_cut_s5,
    output logic             wake_sts
);
    logic ovr_fire, tmr_run, tmr_expired, wake_taken;

    btn_hold_counter #(.HOLD_TICKS(HOLD_TICKS)) u_btn (
        .clk(clk), .rst_n(rst_n), .tick(rtc_tick), .btn_n(pwr_btn_n), .fire(ovr_fire)
    );

    ack_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(ack_timeout), .expired(tmr_expired)
    );

    sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(rtc_tick),
        .cmd_wr(cmd_wr), .cmd_type(cmd_type), .cmd_en(cmd_en), .cmd_psleep(cmd_psleep),
        .stop_ack(stop_ack), .tmr_expired(tmr_expired), .wake_evt(wake_evt),
        .ovr_fire(ovr_fire), .tmr_run(tmr_run), .wake_taken(wake_taken),
        .stop_clk(cpu_stop_clk), .cpu_sleep(cpu_sleep),
        .cut_s3(pwr_cut_s3), .cut_s4(pwr_cut_s4), .cut_s5(pwr_cut_s5)
    );

    wake_status u_wsts (
        .clk(clk), .rst_n(rst_n), .set(wake_taken), .clr(sts_clr), .sts(wake_sts)
    );

    // wake status rises only on a wake seen while sleeping (R9)
    assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_sts) |-> ($past(wake_evt) && $past(cpu_stop_clk)));
    assert_reset_idle_R11: assert property (@(posedge clk)
        !rst_n |-> !(cpu_stop_clk || pwr_cut_s3 || wake_sts));
endmodule

// File: tb/test_acpi_sleep_seq.sv
module test_acpi_sleep_seq;
    localparam int HOLD = 6;
    localparam int TW   = 8;

    logic clk = 1'b0, rst_n = 1'b0, rtc_tick = 1'b0;
    logic cmd_wr = 1'b0, cmd_en = 1'b0, cmd_psleep = 1'b0, sts_clr = 1'b0;
    logic [2:0] cmd_type = 3'd0;
    logic [TW-1:0] ack_timeout = 8'd5;
    logic stop_ack = 1'b0, wake_evt = 1'b0, pwr_btn_n = 1'b1;
    logic cpu_stop_clk, cpu_sleep, pwr_cut_s3, pwr_cut_s4, pwr_cut_s5, wake_sts;

    int vectors = 0, errors = 0, cyc = 0, tick_div = 0;
    string tag = "R11";

    always #4 clk = ~clk;

    acpi_sleep_seq #(.HOLD_TICKS(HOLD), .TMO_W(TW)) i_acpi_sleep_seq (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .cmd_wr(cmd_wr),
        .cmd_type(cmd_type), .cmd_en(cmd_en), .cmd_psleep(cmd_psleep),
        .sts_clr(sts_clr), .ack_timeout(ack_timeout), .stop_ack(stop_ack),
        .wake_evt(wake_evt), .pwr_btn_n(pwr_btn_n), .cpu_stop_clk(cpu_stop_clk),
        .cpu_sleep(cpu_sleep), .pwr_cut_s3(pwr_cut_s3), .pwr_cut_s4(pwr_cut_s4),
        .pwr_cut_s5(pwr_cut_s5), .wake_sts(wake_sts)
    );

    // reference model: phase 0 awake, 1 handshake, 2 asleep, 3 waking
    int phase = 0, level = 0, cuts = 0, waited = 0, held = 0;
    bit m_stp = 0, m_cps = 0, m_psl = 0, m_wsts = 0;

    always @(posedge clk) begin
        bit fire, awake_cmd;
        if (!rst_n) begin
            phase = 0; cuts = 0; waited = 0; held = 0;
            m_stp = 0; m_cps = 0; m_wsts = 0;
        end else begin
            fire = !pwr_btn_n && rtc_tick && held == HOLD - 1;
            m_wsts = (m_wsts && !sts_clr) || (phase == 2 && wake_evt && !fire);
            if (fire) begin
                phase = 2; cuts = 3; m_stp = 1; m_cps = 0;
            end else begin
                case (phase)
                    0: begin
                        awake_cmd = cmd_wr && cmd_en &&
                            (cmd_type == 1 || cmd_type == 5 || cmd_type == 6 || cmd_type == 7);
                        if (awake_cmd) begin
                            phase = 1; waited = 0; m_stp = 1; m_psl = cmd_psleep;
                            level = (cmd_type == 1) ? 1 : int'(cmd_type) - 2;
                        end
                    end
                    1: begin
                        if (stop_ack || waited == int'(ack_timeout)) begin
                            phase = 2;
                            cuts = (level == 1) ? 0 : level - 2;
                            m_cps = (level == 1) && m_psl;
                        end else waited++;
                    end
                    2: if (wake_evt) begin
                        phase = 3; m_cps = 0; cuts = (cuts > 0) ? cuts - 1 : 0;
                    end
                    default: if (rtc_tick) begin
                        if (cuts > 0) cuts--;
                        else begin phase = 0; m_stp = 0; end
                    end
                endcase
            end
            if (pwr_btn_n) held = 0;
            else if (rtc_tick && held < HOLD) held++;
        end
    end

    task automatic cmp(input string name, input logic act, input bit exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, name, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        vectors++;
        cmp("cpu_stop_clk", cpu_stop_clk, m_stp);
        cmp("cpu_sleep", cpu_sleep, m_cps);
        cmp("pwr_cut_s3", pwr_cut_s3, cuts >= 1);
        cmp("pwr_cut_s4", pwr_cut_s4, cuts >= 2);
        cmp("pwr_cut_s5", pwr_cut_s5, cuts == 3);
        cmp("wake_sts", wake_sts, m_wsts);
        tick_div = (tick_div + 1) % 4;
        rtc_tick = (tick_div == 3);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired in %s", tag);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] t, input logic en, input logic ps);
        @(negedge clk);
        cmd_wr = 1; cmd_type = t; cmd_en = en; cmd_psleep = ps;
        @(negedge clk);
        cmd_wr = 0; cmd_en = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); stop_ack = 1; @(negedge clk); stop_ack = 0;
    endtask

    task automatic pulse_wake(input logic also_clr);
        @(negedge clk); wake_evt = 1; sts_clr = also_clr;
        @(negedge clk); wake_evt = 0; sts_clr = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); sts_clr = 1; @(negedge clk); sts_clr = 0;
    endtask

    task automatic hold_btn(input int n);
        @(negedge clk); pwr_btn_n = 0; idle(n); pwr_btn_n = 1;
    endtask

    initial begin
        tag = "R11"; idle(4); rst_n = 1;
        tag = "R2";  cmd(3'd5, 0, 0); idle(3);
        cmd(3'd3, 1, 0); cmd(3'd2, 1, 0); cmd(3'd4, 1, 0); cmd(3'd0, 1, 0); idle(3);
        tag = "R10"; pulse_wake(0); pulse_ack(); idle(2);
        tag = "R1";  ack_timeout = 8'd50; cmd(3'd5, 1, 0); idle(4);
        tag = "R3";  pulse_ack(); idle(3);
        tag = "R10"; cmd(3'd7, 1, 0); idle(3);
        tag = "R8";  pulse_wake(0); idle(12);
        tag = "R9";  pulse_clr(); idle(2);
        tag = "R4";  ack_timeout = 8'd5; cmd(3'd1, 1, 1); idle(10);
        tag = "R5";  idle(2);
        tag = "R8";  pulse_wake(0); idle(8);
        tag = "R5";  cmd(3'd1, 1, 0); idle(10); pulse_wake(0); idle(8);
        tag = "R9";  cmd(3'd6, 1, 0); pulse_ack(); idle(3); pulse_wake(1); idle(12);
        pulse_clr(); idle(2);
        tag = "R6";  cmd(3'd7, 1, 0); pulse_ack(); idle(4);
        tag = "R8";  pulse_wake(0); idle(20);
        tag = "R7";  hold_btn(17); idle(2); hold_btn(17); idle(4);
        hold_btn(40); idle(4); pulse_wake(0); idle(20);
        ack_timeout = 8'd200; cmd(3'd5, 1, 0); hold_btn(40); idle(4);
        pulse_wake(0); idle(20);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule